// File: doc/BRIEF.md
# Banked Bus Decoder with Save-RAM Address Translation

This block sits between a processor and its memory system. Each request carries a 24-bit address (an 8-bit bank above a 16-bit offset), a read/write flag and a width flag (byte or 16-bit). The upper twelve address bits select a 4 KiB page. A writable page table holds a region tag and a speed bit for each page. The region tag decides where each byte goes: plain memory, register space, coprocessor space, low-mapped save RAM, high-mapped save RAM, backup RAM, or nowhere.

The block forms the physical address for the selected target and sends one byte beat at a time over a downstream request port. Downstream reads return in the same cycle. It also does the following:
- It returns open-bus data when a read hits no target.
- It reports a fast/slow cycle class for each byte.
- It keeps a sticky flag that is set when persistent storage is written.
- It drops save-RAM writes while the save-RAM size mask is zero.

A 16-bit access is done as two byte beats, low byte first. If the low thirteen address bits are all ones, the second beat is decoded again as a separate access at address+1.

A state machine runs each access. The states are `ST_IDLE`, `ST_LO`, `ST_HI` and `ST_RESP`, with these transitions:

| From | To | Condition |
|---|---|---|
| `ST_IDLE` | `ST_LO` | a request is accepted |
| `ST_LO` | `ST_HI` | the access is 16-bit |
| `ST_LO` | `ST_RESP` | the access is a byte |
| `ST_HI` | `ST_RESP` | always |
| `ST_RESP` | `ST_IDLE` | always |

Top module: `bank_bus_decoder`

## Requirements
- R1: After reset, every page is unmapped, `save_dirty` is 0, `rsp_valid` is 0 and `req_ready` is 1.
- R2: A `cfg_we` pulse stores `cfg_region` and `cfg_slow` for page `cfg_page`. Region codes are: 0 direct memory, 1 register space, 2 coprocessor, 3 low-mapped save RAM, 4 high-mapped save RAM, 5 backup RAM, 6 and 7 unmapped. The page index is address bits [23:12].
- R3: For low-mapped save RAM, `dn_addr` is the 24-bit address ANDed with `save_mask`.
- R4: For high-mapped save RAM, `dn_addr` is ((addr & 0x7FFF) − 0x6000 + ((addr & 0xF0000) >> 3)) & `save_mask`, computed modulo 2^24.
- R5: For backup RAM, `dn_addr` is (addr & 0x7FFF) − 0x6000, computed modulo 2^24 with no mask applied.
- R6: While `save_mask` is zero, a write to region 3 or 4 issues no downstream beat and leaves `save_dirty` unchanged. Reads in those regions are still issued.
- R7: An issued write to region 3, 4 or 5 sets `save_dirty`. The flag stays set until `dirty_clr` is pulsed. If a marking write and `dirty_clr` fall in the same cycle, the write wins.
- R8: A byte of an unmapped region issues no downstream beat and reads as bits [15:8] of the address that was decoded for it.
- R9: The cycle class is 0 (fast) for register space, the page's `cfg_slow` bit for direct memory, and 1 (slow) for every other region.
- R10: A 16-bit access whose low 13 address bits are not all ones issues its low byte at A and its high byte at A+1. Both bytes use the region, speed and open-bus address decoded for A, even when A+1 lies in another page. Write data is `req_wdata[7:0]` then `req_wdata[15:8]`, and read data returns as {high, low}.
- R11: A 16-bit access with A[12:0] = 0x1FFF decodes its second byte afresh at the full 24-bit address A+1, including region, speed, translation and open-bus value.
- R12: `req_ready` is high only in `ST_IDLE`. `rsp_valid` is a single-cycle pulse in `ST_RESP`. A byte access reports `rsp_class_hi` = 0 and `rsp_rdata[15:8]` = 0.
- R13: Direct memory uses the full address as `dn_addr`. Register and coprocessor space use the 16-bit offset, zero-extended.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| cfg_we | input | 1 | Page table write strobe |
| cfg_page | input | 12 | Page index to write |
| cfg_region | input | 3 | Region code to store |
| cfg_slow | input | 1 | Speed bit to store (1 = slow) |
| save_mask | input | 24 | Save-RAM size mask |
| dirty_clr | input | 1 | Clears the modified flag |
| req_valid | input | 1 | Access request |
| req_write | input | 1 | 1 = write |
| req_wide | input | 1 | 1 = 16-bit access |
| req_addr | input | 24 | Bank and offset |
| req_wdata | input | 16 | Write data |
| req_ready | output | 1 | Block is idle and accepts a request |
| rsp_valid | output | 1 | Response pulse |
| rsp_rdata | output | 16 | Read data {high, low} |
| rsp_class_lo | output | 1 | Cycle class of the first byte |
| rsp_class_hi | output | 1 | Cycle class of the second byte |
| dn_req | output | 1 | Downstream byte beat |
| dn_we | output | 1 | Downstream beat is a write |
| dn_region | output | 3 | Region code of the beat |
| dn_addr | output | 24 | Translated physical address |
| dn_wdata | output | 8 | Byte to write |
| dn_rdata | input | 8 | Byte read, valid in the same cycle |
| save_dirty | output | 1 | Sticky modified flag |

## Verification
The assertions check several rules on every cycle:
- No downstream beat is ever issued for an unmapped region.
- No save-RAM write reaches the port while the mask is zero.
- The response is a single pulse that never overlaps readiness.
- The modified flag is sticky, is set by backup-RAM writes, and is cleared by `dirty_clr` unless a marking write arrives in the same cycle.

The bench's scenarios are needed for the rest:
- the address arithmetic of each region;
- the open-bus byte values;
- per-page speed classes;
- the different second-byte decoding of split and non-split 16-bit accesses, including a page crossing that must not be decoded again.

// File: rtl/bbd_pkg.sv
package bbd_pkg;

    typedef enum logic [2:0] {
        RG_DIRECT  = 3'd0,
        RG_REGS    = 3'd1,
        RG_COPRO   = 3'd2,
        RG_SAVE_LO = 3'd3,
        RG_SAVE_HI = 3'd4,
        RG_BACKUP  = 3'd5,
        RG_NONE    = 3'd6,
        RG_NONE_B  = 3'd7
    } region_e;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_LO   = 2'd1,
        ST_HI   = 2'd2,
        ST_RESP = 2'd3
    } state_e;

    typedef struct packed {
        logic    slow;
        region_e tag;
    } page_ent_t;

endpackage

// File: rtl/bbd_page_table.sv
module bbd_page_table
    import bbd_pkg::*;
#(
    parameter int PAGE_BITS = 12
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr_en,
    input  logic [PAGE_BITS-1:0] wr_page,
    input  page_ent_t            wr_ent,
    input  logic [PAGE_BITS-1:0] rd_page,
    output page_ent_t            rd_ent
);
    localparam int PAGES = 1 << PAGE_BITS;

    page_ent_t ent_q [PAGES];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < PAGES; i++) begin
                ent_q[i] <= '{slow: 1'b0, tag: RG_NONE};
            end
        end else if (wr_en) begin
            ent_q[wr_page] <= wr_ent;
        end
    end

    assign rd_ent = ent_q[rd_page];

endmodule

// File: rtl/bbd_xlate.sv
module bbd_xlate
    import bbd_pkg::*;
#(
    parameter int ADDR_W = 24
) (
    input  region_e           tag,
    input  logic              page_slow,
    input  logic              is_write,
    input  logic [ADDR_W-1:0] addr,
    input  logic [ADDR_W-1:0] mask,
    output logic [ADDR_W-1:0] phys,
    output logic              slow,
    output logic              issue,
    output logic              marks_dirty
);
    localparam logic [ADDR_W-1:0] WIN_BASE = ADDR_W'(24'h006000);

    logic [ADDR_W-1:0] win;
    logic [ADDR_W-1:0] bank_fold;
    logic [ADDR_W-1:0] offset16;
    logic              is_save;
    logic              unmapped;

    always_comb begin
        win            = '0;
        win[14:0]      = addr[14:0];
        bank_fold      = '0;
        bank_fold[16:13] = addr[19:16];
        offset16       = '0;
        offset16[15:0] = addr[15:0];
        is_save        = (tag == RG_SAVE_LO) || (tag == RG_SAVE_HI);
        unmapped       = (tag == RG_NONE) || (tag == RG_NONE_B);

        unique case (tag)
            RG_DIRECT:  phys = addr;
            RG_REGS:    phys = offset16;
            RG_COPRO:   phys = offset16;
            RG_SAVE_LO: phys = addr & mask;
            RG_SAVE_HI: phys = (win - WIN_BASE + bank_fold) & mask;
            RG_BACKUP:  phys = win - WIN_BASE;
            default:    phys = '0;
        endcase

        unique case (tag)
            RG_REGS:   slow = 1'b0;
            RG_DIRECT: slow = page_slow;
            default:   slow = 1'b1;
        endcase

        issue       = !unmapped && !(is_write && is_save && (mask == '0));
        marks_dirty = is_write && issue && (is_save || (tag == RG_BACKUP));
    end

endmodule

// File: rtl/bank_bus_decoder.sv
module bank_bus_decoder
    import bbd_pkg::*;
#(
    parameter int ADDR_W     = 24,
    parameter int PAGE_BITS  = 12,
    parameter int SPLIT_BITS = 13
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 cfg_we,
    input  logic [PAGE_BITS-1:0] cfg_page,
    input  logic [2:0]           cfg_region,
    input  logic                 cfg_slow,
    input  logic [ADDR_W-1:0]    save_mask,
    input  logic                 dirty_clr,
    input  logic                 req_valid,
    input  logic                 req_write,
    input  logic                 req_wide,
    input  logic [ADDR_W-1:0]    req_addr,
    input  logic [15:0]          req_wdata,
    output logic                 req_ready,
    output logic                 rsp_valid,
    output logic [15:0]          rsp_rdata,
    output logic                 rsp_class_lo,
    output logic                 rsp_class_hi,
    output logic                 dn_req,
    output logic                 dn_we,
    output logic [2:0]           dn_region,
    output logic [ADDR_W-1:0]    dn_addr,
    output logic [7:0]           dn_wdata,
    input  logic [7:0]           dn_rdata,
    output logic                 save_dirty
);
    localparam int PAGE_LSB = ADDR_W - PAGE_BITS;

    state_e            st_q, st_d;
    logic [ADDR_W-1:0] a_q;
    logic              we_q, wide_q;
    logic [15:0]       wd_q;
    region_e           tag_q;
    logic              spd_q;
    logic [7:0]        rd_lo_q, rd_hi_q;
    logic              cls_lo_q, cls_hi_q, dirty_q;

    logic              in_hi, beat_on, split, redecode;
    logic [ADDR_W-1:0] a_next, beat_addr, ob_addr;
    page_ent_t         look, cfg_ent;
    region_e           eff_tag;
    logic              eff_slow;
    logic [ADDR_W-1:0] x_phys;
    logic              x_slow, x_issue, x_dirty;
    logic [7:0]        beat_byte;

    // Beat address and region selection
    always_comb begin
        in_hi     = (st_q == ST_HI);
        beat_on   = (st_q == ST_LO) || (st_q == ST_HI);
        split     = (a_q[SPLIT_BITS-1:0] == '1);
        a_next    = a_q + ADDR_W'(1);
        beat_addr = in_hi ? a_next : a_q;
        redecode  = !in_hi || split;
        eff_tag   = redecode ? look.tag  : tag_q;
        eff_slow  = redecode ? look.slow : spd_q;
        ob_addr   = (in_hi && split) ? a_next : a_q;
        beat_byte = x_issue ? dn_rdata : ob_addr[15:8];
        cfg_ent   = '{slow: cfg_slow, tag: region_e'(cfg_region)};
    end

    bbd_page_table #(.PAGE_BITS(PAGE_BITS)) u_table (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (cfg_we),
        .wr_page (cfg_page),
        .wr_ent  (cfg_ent),
        .rd_page (beat_addr[ADDR_W-1:PAGE_LSB]),
        .rd_ent  (look)
    );

    bbd_xlate #(.ADDR_W(ADDR_W)) u_xlate (
        .tag         (eff_tag),
        .page_slow   (eff_slow),
        .is_write    (we_q),
        .addr        (beat_addr),
        .mask        (save_mask),
        .phys        (x_phys),
        .slow        (x_slow),
        .issue       (x_issue),
        .marks_dirty (x_dirty)
    );

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= ST_IDLE;
        else        st_q <= st_d;
    end

    // Transitions
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ST_IDLE: if (req_valid) st_d = ST_LO;
            ST_LO:   st_d = wide_q ? ST_HI : ST_RESP;
            ST_HI:   st_d = ST_RESP;
            ST_RESP: st_d = ST_IDLE;
        endcase
    end

    // Datapath registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            a_q      <= '0;
            we_q     <= 1'b0;
            wide_q   <= 1'b0;
            wd_q     <= '0;
            tag_q    <= RG_NONE;
            spd_q    <= 1'b0;
            rd_lo_q  <= '0;
            rd_hi_q  <= '0;
            cls_lo_q <= 1'b0;
            cls_hi_q <= 1'b0;
        end else begin
            unique case (st_q)
                ST_IDLE: if (req_valid) begin
                    a_q      <= req_addr;
                    we_q     <= req_write;
                    wide_q   <= req_wide;
                    wd_q     <= req_wdata;
                    rd_hi_q  <= '0;
                    cls_hi_q <= 1'b0;
                end
                ST_LO: begin
                    tag_q    <= eff_tag;
                    spd_q    <= eff_slow;
                    rd_lo_q  <= beat_byte;
                    cls_lo_q <= x_slow;
                end
                ST_HI: begin
                    rd_hi_q  <= beat_byte;
                    cls_hi_q <= x_slow;
                end
                ST_RESP: ;
            endcase
        end
    end

    // Sticky modified flag: a marking write beats a clear
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                  dirty_q <= 1'b0;
        else if (beat_on && x_dirty) dirty_q <= 1'b1;
        else if (dirty_clr)          dirty_q <= 1'b0;
    end

    // Outputs
    always_comb begin
        req_ready    = (st_q == ST_IDLE);
        rsp_valid    = (st_q == ST_RESP);
        rsp_rdata    = {rd_hi_q, rd_lo_q};
        rsp_class_lo = cls_lo_q;
        rsp_class_hi = cls_hi_q;
        dn_req       = beat_on && x_issue;
        dn_we        = dn_req && we_q;
        dn_region    = eff_tag;
        dn_addr      = x_phys;
        dn_wdata     = in_hi ? wd_q[15:8] : wd_q[7:0];
        save_dirty   = dirty_q;
    end

endmodule

// File: rtl/bbd_checker.sv
module bbd_checker #(
    parameter int ADDR_W = 24
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_ready,
    input logic              rsp_valid,
    input logic              dn_req,
    input logic              dn_we,
    input logic [2:0]        dn_region,
    input logic [ADDR_W-1:0] save_mask,
    input logic              dirty_clr,
    input logic              save_dirty
);
    logic marking_wr;
    assign marking_wr = dn_req && dn_we && (dn_region >= 3'd3) && (dn_region <= 3'd5);

    assert_rsp_pulse_R12: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> !rsp_valid);

    assert_rsp_not_ready_R12: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> !req_ready);

    assert_beat_busy_R12: assert property (@(posedge clk) disable iff (!rst_n)
        dn_req |-> !req_ready);

    assert_no_masked_write_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (dn_req && dn_we && (dn_region == 3'd3 || dn_region == 3'd4)) |-> (save_mask != '0));

    assert_unmapped_silent_R8: assert property (@(posedge clk) disable iff (!rst_n)
        dn_req |-> (dn_region < 3'd6));

    assert_dirty_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (save_dirty && !dirty_clr) |=> save_dirty);

    assert_backup_marks_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (dn_req && dn_we && dn_region == 3'd5) |=> save_dirty);

    assert_dirty_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (dirty_clr && !marking_wr) |=> !save_dirty);

endmodule

bind bank_bus_decoder bbd_checker #(.ADDR_W(ADDR_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_ready  (req_ready),
    .rsp_valid  (rsp_valid),
    .dn_req     (dn_req),
    .dn_we      (dn_we),
    .dn_region  (dn_region),
    .save_mask  (save_mask),
    .dirty_clr  (dirty_clr),
    .save_dirty (save_dirty)
);

// File: tb/test_bank_bus_decoder.sv
module test_bank_bus_decoder;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [11:0] cfg_page = '0;
    logic [2:0]  cfg_region = '0;
    logic        cfg_slow = 1'b0;
    logic [23:0] save_mask = '0;
    logic        dirty_clr = 1'b0;
    logic        req_valid = 1'b0, req_write = 1'b0, req_wide = 1'b0;
    logic [23:0] req_addr = '0;
    logic [15:0] req_wdata = '0;
    logic        req_ready, rsp_valid, rsp_class_lo, rsp_class_hi;
    logic [15:0] rsp_rdata;
    logic        dn_req, dn_we;
    logic [2:0]  dn_region;
    logic [23:0] dn_addr;
    logic [7:0]  dn_wdata, dn_rdata;
    logic        save_dirty;

    int total = 0;
    int fails = 0;
    int cyc = 0;
    logic [2:0] sh_tag [4096];
    logic       sh_slow [4096];
    logic       exp_dirty = 1'b0;

    logic [23:0] lg_addr [4];
    logic [2:0]  lg_reg [4];
    logic        lg_we [4];
    logic [7:0]  lg_wd [4];
    int          nb = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic logic [7:0] mem_byte(input logic [23:0] a, input logic [2:0] r);
        return a[7:0] ^ a[15:8] ^ a[23:16] ^ {5'd0, r};
    endfunction

    assign dn_rdata = mem_byte(dn_addr, dn_region);

    bank_bus_decoder i_bank_bus_decoder (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_page(cfg_page),
        .cfg_region(cfg_region), .cfg_slow(cfg_slow), .save_mask(save_mask),
        .dirty_clr(dirty_clr), .req_valid(req_valid), .req_write(req_write),
        .req_wide(req_wide), .req_addr(req_addr), .req_wdata(req_wdata),
        .req_ready(req_ready), .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
        .rsp_class_lo(rsp_class_lo), .rsp_class_hi(rsp_class_hi),
        .dn_req(dn_req), .dn_we(dn_we), .dn_region(dn_region), .dn_addr(dn_addr),
        .dn_wdata(dn_wdata), .dn_rdata(dn_rdata), .save_dirty(save_dirty)
    );

    always @(posedge clk) begin
        if (rst_n && dn_req && nb < 4) begin
            lg_addr[nb] = dn_addr;
            lg_reg[nb]  = dn_region;
            lg_we[nb]   = dn_we;
            lg_wd[nb]   = dn_wdata;
            nb = nb + 1;
        end
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    function automatic logic [23:0] ref_phys(input logic [2:0] r, input logic [23:0] a,
                                             input logic [23:0] m);
        logic [23:0] low15 = {9'd0, a[14:0]};
        case (r)
            3'd0:    return a;                                        // R13
            3'd1,
            3'd2:    return {8'd0, a[15:0]};                          // R13
            3'd3:    return a & m;                                    // R3
            3'd4:    return (low15 - 24'h6000 + ({4'd0, a[19:16], 16'd0} >> 3)) & m; // R4
            3'd5:    return low15 - 24'h6000;                         // R5
            default: return 24'd0;
        endcase
    endfunction

    task automatic set_page(input logic [11:0] p, input logic [2:0] r, input logic s);
        @(negedge clk);
        cfg_we = 1'b1; cfg_page = p; cfg_region = r; cfg_slow = s;
        @(negedge clk);
        cfg_we = 1'b0;
        sh_tag[p] = r; sh_slow[p] = s;
    endtask

    task automatic clear_dirty();
        @(negedge clk);
        dirty_clr = 1'b1;
        @(negedge clk);
        dirty_clr = 1'b0;
        exp_dirty = 1'b0;
        chk("R7 clear", {31'd0, save_dirty}, 32'd0);
    endtask

    task automatic access(input logic w, input logic wide, input logic [23:0] a,
                          input logic [15:0] d);
        logic [23:0] e_addr [2];
        logic [2:0]  e_reg [2];
        logic [7:0]  e_wd [2];
        logic [7:0]  byt [2];
        logic        cls [2];
        int          ne = 0;
        logic [2:0]  tag0 = sh_tag[a[23:12]];
        logic        spd0 = sh_slow[a[23:12]];
        logic        split = (a[12:0] == 13'h1FFF);
        byt[1] = 8'd0; cls[1] = 1'b0;
        for (int k = 0; k < (wide ? 2 : 1); k++) begin
            logic [23:0] ba = (k == 1) ? a + 24'd1 : a;
            logic        fresh = (k == 0) || split;          // R10 / R11
            logic [2:0]  r = fresh ? sh_tag[ba[23:12]] : tag0;
            logic        s = fresh ? sh_slow[ba[23:12]] : spd0;
            logic [7:0]  ob = fresh ? ba[15:8] : a[15:8];   // R8
            logic        save = (r == 3'd3) || (r == 3'd4);
            logic        iss = (r < 3'd6) && !(w && save && save_mask == 24'd0);
            logic [23:0] ph = ref_phys(r, ba, save_mask);
            byt[k] = iss ? mem_byte(ph, r) : ob;
            cls[k] = (r == 3'd1) ? 1'b0 : ((r == 3'd0) ? s : 1'b1); // R9
            if (iss) begin
                e_addr[ne] = ph; e_reg[ne] = r; e_wd[ne] = (k == 1) ? d[15:8] : d[7:0];
                ne++;
                if (w && (save || r == 3'd5)) exp_dirty = 1'b1;       // R7
            end
        end
        @(negedge clk);
        chk("R12 ready when idle", {31'd0, req_ready}, 32'd1);
        nb = 0;
        req_valid = 1'b1; req_write = w; req_wide = wide; req_addr = a; req_wdata = d;
        @(negedge clk);
        req_valid = 1'b0;
        while (!rsp_valid) @(negedge clk);
        chk("R8 R6 beat count", nb, ne);
        for (int j = 0; j < ne && j < nb; j++) begin
            chk("R3 R4 R5 R13 beat address", {8'd0, lg_addr[j]}, {8'd0, e_addr[j]});
            chk("R10 R11 beat region", {29'd0, lg_reg[j]}, {29'd0, e_reg[j]});
            chk("R10 beat write flag", {31'd0, lg_we[j]}, {31'd0, w});
            if (w) chk("R10 beat write data", {24'd0, lg_wd[j]}, {24'd0, e_wd[j]});
        end
        if (!w) chk("R8 R10 R11 read data", {16'd0, rsp_rdata}, {16'd0, byt[1], byt[0]});
        chk("R9 class lo", {31'd0, rsp_class_lo}, {31'd0, cls[0]});
        chk("R9 R12 class hi", {31'd0, rsp_class_hi}, {31'd0, cls[1]});
        chk("R7 dirty", {31'd0, save_dirty}, {31'd0, exp_dirty});
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc == 150000) begin
            total++; fails++;
            $display("FAIL watchdog: actual hung expected done");
            $display("%0d/%0d checks passed", total - fails, total);
            $finish;
        end
    end

    logic [11:0] pg [12] = '{12'h7E0, 12'h7E1, 12'h002, 12'h003, 12'h700, 12'h306,
                             12'h316, 12'h406, 12'h300, 12'h301, 12'h302, 12'h555};
    logic [23:0] masks [4] = '{24'h000000, 24'h001FFF, 24'h00FFFF, 24'h07FFFF};

    initial begin
        void'($urandom(32'd5150));
        for (int i = 0; i < 4096; i++) begin sh_tag[i] = 3'd6; sh_slow[i] = 1'b0; end
        repeat (3) @(negedge clk);
        chk("R1 reset rsp_valid", {31'd0, rsp_valid}, 32'd0);
        chk("R1 reset dirty", {31'd0, save_dirty}, 32'd0);
        rst_n = 1'b1;
        chk("R1 reset ready", {31'd0, req_ready}, 32'd1);
        access(1'b0, 1'b0, 24'h123456, 16'h0);        // R1 every page unmapped

        set_page(12'h7E0, 3'd0, 1'b0);                // R2
        set_page(12'h7E1, 3'd0, 1'b1);
        set_page(12'h002, 3'd1, 1'b1);
        set_page(12'h003, 3'd2, 1'b0);
        set_page(12'h700, 3'd3, 1'b0);
        set_page(12'h306, 3'd4, 1'b0);
        set_page(12'h316, 3'd4, 1'b0);
        set_page(12'h406, 3'd5, 1'b0);
        set_page(12'h300, 3'd5, 1'b0);
        set_page(12'h301, 3'd0, 1'b0);
        set_page(12'h302, 3'd1, 1'b0);

        access(1'b0, 1'b0, 24'h7E0010, 16'h0);        // R9 fast direct, R13
        access(1'b0, 1'b0, 24'h7E1020, 16'h0);        // R9 slow direct
        access(1'b0, 1'b0, 24'h002118, 16'h0);        // R9 register space fast
        access(1'b0, 1'b0, 24'h003A00, 16'h0);        // R13 coprocessor
        save_mask = 24'h001FFF;
        access(1'b1, 1'b0, 24'h700ABC, 16'h005A);     // R3 R7
        clear_dirty();                                // R7
        save_mask = 24'h0FFFFF;
        access(1'b1, 1'b0, 24'h316123, 16'h0033);     // R4 bank fold
        clear_dirty();
        save_mask = 24'h000000;
        access(1'b1, 1'b0, 24'h316123, 16'h0044);     // R6 dropped
        access(1'b1, 1'b0, 24'h700010, 16'h0045);     // R6 dropped
        access(1'b0, 1'b0, 24'h700010, 16'h0);        // R6 read still issued
        access(1'b1, 1'b0, 24'h406050, 16'h0077);     // R5 R7 backup ignores mask
        // R7 same-cycle clear loses to marking write
        @(negedge clk);
        dirty_clr = 1'b1;
        access(1'b1, 1'b0, 24'h406051, 16'h0078);
        dirty_clr = 1'b0;
        access(1'b0, 1'b1, 24'h300FFF, 16'h0);        // R10 page cross, no redecode
        access(1'b0, 1'b1, 24'h301FFF, 16'h0);        // R11 split redecode
        access(1'b1, 1'b1, 24'h301FFF, 16'hBEEF);     // R11 split write
        access(1'b0, 1'b1, 24'h555F00, 16'h0);        // R8 R10 unmapped word
        access(1'b1, 1'b1, 24'h7E0100, 16'hCAFE);     // R10 little-endian write

        for (int it = 0; it < 400; it++) begin
            logic [11:0] p = pg[$urandom_range(0, 11)];
            logic [11:0] off = 12'($urandom_range(0, 4095));
            if (it % 7 == 0) off = 12'hFFF;
            if (it % 40 == 0) save_mask = masks[$urandom_range(0, 3)];
            if (it % 55 == 0) clear_dirty();
            access(1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)), {p, off},
                   16'($urandom_range(0, 65535)));
        end

        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

endmodule